// File: doc/BRIEF.md
# Dual-Port Fully Associative Translation CAM

This block is a small, fully associative translation buffer for a fixed 4 KB page. Each of its 32 slots holds a virtual page number, a region identifier, a physical page number and a valid flag. Two lookup ports work independently in the same cycle. Each port compares a 64-bit address against every slot at once and returns a registered vector with one bit per slot. It also returns the physical page number of the matching slot.

The per-slot vector is the main result. A tag array that stores, for each line, a pointer to the translating slot can select the correct way by AND-ing its stored bits with this vector. It then needs no comparison of physical addresses.

A per-port mode bit switches the same compare path to the physical page field. This lets a caller find every slot that translates to a given physical page, for example to invalidate it. One write port installs or removes a single slot. The slot index comes from outside, so the replacement choice belongs to the caller. A flush input clears every valid flag in one cycle.

Top module: `xlat_cam`

## Requirements
- R1: While reset is asserted, and after it is released, every hit vector and every physical page output reads zero and no slot is valid, so no lookup hits until a slot is written.
- R2: In virtual mode (mode bit 0), bit i of a port's hit vector is set one cycle after a lookup exactly when slot i is valid, its virtual page equals address bits [63:12], and its region equals the port's region input.
- R3: In physical mode (mode bit 1), bit i is set one cycle after a lookup exactly when slot i is valid and its physical page equals address bits [49:12]; the region input and address bits [63:50] have no effect, and several bits may be set at once.
- R4: A port's physical page output is the bitwise OR of the physical pages of all slots set in its hit vector, so it equals the matching slot's page on a single hit and is zero on a miss.
- R5: The two lookup ports are independent: each produces its own result in the same cycle from its own mode, address and region.
- R6: A write stores the virtual page, region, physical page and valid flag at the given slot index; lookups issued from the next cycle see it, and a write with valid 0 removes the slot from all matches.
- R7: A lookup issued in the same cycle as a write to the slot it targets returns the slot's contents from before that write.
- R8: Asserting the flush input clears every valid flag in one cycle, including that of a slot written in the same cycle; lookups issued afterwards miss until new writes arrive.
- R9: While a port's lookup enable is low, its hit vector and physical page output hold their previous values.
- R10: Address bits [11:0] never affect a lookup in either mode.
- R11: In virtual mode, a port reports at most one hit as long as no two valid slots hold the same virtual page and region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_slot | input | 5 | Slot index to write |
| wr_valid | input | 1 | Valid flag stored with the write |
| wr_vpn | input | 52 | Virtual page number to store |
| wr_ppn | input | 38 | Physical page number to store |
| wr_rgn | input | 24 | Region identifier to store |
| inv_all | input | 1 | Clears every valid flag |
| lk_en | input | 2 | Per-port lookup enable |
| lk_mode | input | 2 | Per-port compare mode: 0 virtual, 1 physical |
| lk_addr | input | 2x64 | Per-port lookup address |
| lk_rgn | input | 2x24 | Per-port region identifier |
| lk_hit_vec | output | 2x32 | Per-port registered one-bit-per-slot match vector |
| lk_ppn | output | 2x38 | Per-port registered physical page of the matching slots |

## Verification
A lookup presented before a rising edge shows its hit vector and physical page after that edge. The result reflects the table as it stood before that edge. A write or flush sampled at the same edge first affects a lookup presented for the next edge. The bench drives inputs and samples outputs on the falling edge. It computes the expected result from its own table model before the edge and updates the model with the write or flush only afterwards. One-cycle effects such as old-contents reads, flushes that override a simultaneous write, and holding while disabled are therefore compared in the exact cycle they are due.

// File: rtl/xlat_cam_pkg.sv
package xlat_cam_pkg;
  localparam int CAM_ENTRIES   = 32;
  localparam int CAM_ADDR_W    = 64;
  localparam int CAM_PA_W      = 50;
  localparam int CAM_PAGE_BITS = 12;
  localparam int CAM_RGN_W     = 24;
  localparam int CAM_PORTS     = 2;

  typedef enum logic {
    MATCH_VIRT = 1'b0,
    MATCH_PHYS = 1'b1
  } match_mode_e;
endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 52,
  parameter int PPN_W   = 38,
  parameter int RGN_W   = 24,
  parameter int SLOT_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SLOT_W-1:0]              wr_slot,
  input  logic                           wr_valid,
  input  logic [VPN_W-1:0]               wr_vpn,
  input  logic [PPN_W-1:0]               wr_ppn,
  input  logic [RGN_W-1:0]               wr_rgn,
  input  logic                           inv_all,
  output logic [ENTRIES-1:0]             ent_vld,
  output logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  output logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
  output logic [ENTRIES-1:0][RGN_W-1:0]  ent_rgn
);
  logic [ENTRIES-1:0] vld_q, vld_d;

  // valid flags: flush overrides any write in the same cycle
  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_slot] = wr_valid;
    if (inv_all) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload fields: no reset, loaded only on a write to the slot
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_slot == SLOT_W'(i));
    always_ff @(posedge clk) begin
      if (sel) begin
        ent_vpn[i] <= wr_vpn;
        ent_ppn[i] <= wr_ppn;
        ent_rgn[i] <= wr_rgn;
      end
    end
  end

  assign ent_vld = vld_q;
endmodule

// File: rtl/xlat_match_port.sv
module xlat_match_port
  import xlat_cam_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 52,
  parameter int PPN_W   = 38,
  parameter int RGN_W   = 24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lk_en,
  input  logic                           lk_mode,
  input  logic [VPN_W-1:0]               lk_vpn,
  input  logic [RGN_W-1:0]               lk_rgn,
  input  logic [ENTRIES-1:0]             ent_vld,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
  input  logic [ENTRIES-1:0][RGN_W-1:0]  ent_rgn,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic [PPN_W-1:0]               hit_ppn
);
  logic [ENTRIES-1:0] hit_d, hit_q;
  logic [PPN_W-1:0]   ppn_d, ppn_q;

  // parallel compare against every slot
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic virt_eq, phys_eq;
    assign virt_eq = (lk_vpn == ent_vpn[i]) && (lk_rgn == ent_rgn[i]);
    assign phys_eq = (lk_vpn[PPN_W-1:0] == ent_ppn[i]);
    assign hit_d[i] = ent_vld[i] &&
                      ((lk_mode == MATCH_PHYS) ? phys_eq : virt_eq);
  end

  // page of the hit slots as a wired OR
  always_comb begin
    ppn_d = '0;
    for (int i = 0; i < ENTRIES; i++)
      ppn_d = ppn_d | (ent_ppn[i] & {PPN_W{hit_d[i]}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      ppn_q <= '0;
    end else if (lk_en) begin
      hit_q <= hit_d;
      ppn_q <= ppn_d;
    end
  end

  assign hit_vec = hit_q;
  assign hit_ppn = ppn_q;
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_cam_pkg::*;
#(
  parameter int ENTRIES   = CAM_ENTRIES,
  parameter int ADDR_W    = CAM_ADDR_W,
  parameter int PA_W      = CAM_PA_W,
  parameter int PAGE_BITS = CAM_PAGE_BITS,
  parameter int RGN_W     = CAM_RGN_W,
  parameter int PORTS     = CAM_PORTS,
  localparam int SLOT_W   = $clog2(ENTRIES),
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  logic                          wr_valid,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [PPN_W-1:0]              wr_ppn,
  input  logic [RGN_W-1:0]              wr_rgn,
  input  logic                          inv_all,
  input  logic [PORTS-1:0]              lk_en,
  input  logic [PORTS-1:0]              lk_mode,
  input  logic [PORTS-1:0][ADDR_W-1:0]  lk_addr,
  input  logic [PORTS-1:0][RGN_W-1:0]   lk_rgn,
  output logic [PORTS-1:0][ENTRIES-1:0] lk_hit_vec,
  output logic [PORTS-1:0][PPN_W-1:0]   lk_ppn
);
  logic [ENTRIES-1:0]            ent_vld;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [ENTRIES-1:0][RGN_W-1:0] ent_rgn;

  xlat_entry_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .RGN_W(RGN_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_valid(wr_valid),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_rgn(wr_rgn), .inv_all(inv_all),
    .ent_vld(ent_vld), .ent_vpn(ent_vpn), .ent_ppn(ent_ppn), .ent_rgn(ent_rgn)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic unused_offset;
    assign unused_offset = ^lk_addr[p][PAGE_BITS-1:0];

    xlat_match_port #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .RGN_W(RGN_W)
    ) u_port (
      .clk(clk), .rst_n(rst_n),
      .lk_en(lk_en[p]), .lk_mode(lk_mode[p]),
      .lk_vpn(lk_addr[p][ADDR_W-1:PAGE_BITS]), .lk_rgn(lk_rgn[p]),
      .ent_vld(ent_vld), .ent_vpn(ent_vpn), .ent_ppn(ent_ppn), .ent_rgn(ent_rgn),
      .hit_vec(lk_hit_vec[p]), .hit_ppn(lk_ppn[p])
    );
  end
endmodule

// File: rtl/xlat_cam_chk.sv
module xlat_cam_chk #(
  parameter int ENTRIES   = 32,
  parameter int ADDR_W    = 64,
  parameter int PA_W      = 50,
  parameter int PAGE_BITS = 12,
  parameter int RGN_W     = 24,
  parameter int PORTS     = 2,
  localparam int SLOT_W   = $clog2(ENTRIES),
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [SLOT_W-1:0]             wr_slot,
  input logic                          wr_valid,
  input logic [VPN_W-1:0]              wr_vpn,
  input logic [PPN_W-1:0]              wr_ppn,
  input logic [RGN_W-1:0]              wr_rgn,
  input logic                          inv_all,
  input logic [PORTS-1:0]              lk_en,
  input logic [PORTS-1:0]              lk_mode,
  input logic [PORTS-1:0][ADDR_W-1:0]  lk_addr,
  input logic [PORTS-1:0][RGN_W-1:0]   lk_rgn,
  input logic [PORTS-1:0][ENTRIES-1:0] lk_hit_vec,
  input logic [PORTS-1:0][PPN_W-1:0]   lk_ppn
);
  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    // R9: disabled port keeps its result
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(lk_en[p]) |-> ($stable(lk_hit_vec[p]) && $stable(lk_ppn[p])));

    // R11: unique table gives at most one virtual hit
    p_single_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lk_en[p]) && !$past(lk_mode[p])) |-> $onehot0(lk_hit_vec[p]));

    // R8: lookup issued after a flush misses
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inv_all, 2) && $past(lk_en[p])) |-> (lk_hit_vec[p] == '0));

    // R6: installed slot is found by the next virtual lookup
    p_install_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en, 2) && $past(wr_valid, 2) && !$past(inv_all, 2) &&
       $past(lk_en[p]) && !$past(lk_mode[p]) &&
       ($past(lk_addr[p][ADDR_W-1:PAGE_BITS]) == $past(wr_vpn, 2)) &&
       ($past(lk_rgn[p]) == $past(wr_rgn, 2)))
      |-> (lk_hit_vec[p][$past(wr_slot, 2)] && (lk_ppn[p] == $past(wr_ppn, 2))));

    // R4: a miss reports page zero
    p_miss_zero_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lk_en[p]) && (lk_hit_vec[p] == '0)) |-> (lk_ppn[p] == '0));
  end
endmodule

bind xlat_cam xlat_cam_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PA_W(PA_W),
  .PAGE_BITS(PAGE_BITS), .RGN_W(RGN_W), .PORTS(PORTS)
) u_chk (.*);

// File: tb/test_xlat_cam.sv
module test_xlat_cam;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_valid = 1'b0, inv_all = 1'b0;
  logic [4:0] wr_slot = '0;
  logic [51:0] wr_vpn = '0;
  logic [37:0] wr_ppn = '0;
  logic [23:0] wr_rgn = '0;
  logic [1:0] lk_en = '0, lk_mode = '0;
  logic [1:0][63:0] lk_addr = '0;
  logic [1:0][23:0] lk_rgn = '0;
  logic [1:0][31:0] lk_hit_vec;
  logic [1:0][37:0] lk_ppn;

  always #4 clk = ~clk;

  xlat_cam i_xlat_cam (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic        m_vld [N];
  logic [51:0] m_vpn [N];
  logic [37:0] m_ppn [N];
  logic [23:0] m_rgn [N];
  logic [31:0] exp_vec [2];
  logic [37:0] exp_ppn [2];

  function automatic logic [31:0] model_vec(logic md, logic [63:0] a, logic [23:0] r);
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++)
      if (m_vld[i])
        v[i] = md ? (m_ppn[i] == a[49:12]) : ((m_vpn[i] == a[63:12]) && (m_rgn[i] == r));
    return v;
  endfunction

  function automatic logic [37:0] model_ppn(logic [31:0] v);
    logic [37:0] q = '0;
    for (int i = 0; i < N; i++) if (v[i]) q |= m_ppn[i];
    return q;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic quiet();
    wr_en = 0; wr_valid = 0; inv_all = 0; lk_en = '0;
  endtask

  // one clock: expected from pre-edge model, then model update, then check
  task automatic cycle(string tag);
    logic [1:0] md = lk_mode;
    logic [1:0] en = lk_en;
    for (int p = 0; p < 2; p++)
      if (en[p]) begin
        exp_vec[p] = model_vec(lk_mode[p], lk_addr[p], lk_rgn[p]);
        exp_ppn[p] = model_ppn(exp_vec[p]);
      end
    @(posedge clk);
    if (wr_en) begin
      m_vpn[wr_slot] = wr_vpn; m_ppn[wr_slot] = wr_ppn;
      m_rgn[wr_slot] = wr_rgn; m_vld[wr_slot] = wr_valid;
    end
    if (inv_all) for (int i = 0; i < N; i++) m_vld[i] = 0;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      check(tag, $sformatf("port%0d hit vector", p), 64'(lk_hit_vec[p]), 64'(exp_vec[p]));
      check(tag, $sformatf("port%0d page", p), 64'(lk_ppn[p]), 64'(exp_ppn[p]));
      if (en[p] && !md[p])
        check("R11", $sformatf("port%0d multi-hit", p),
              64'($countones(lk_hit_vec[p]) > 1), 64'(0));
    end
  endtask

  task automatic do_write(int s, logic [51:0] v, logic [37:0] pp, logic [23:0] r, logic vl);
    wr_en = 1; wr_slot = 5'(s); wr_vpn = v; wr_ppn = pp; wr_rgn = r; wr_valid = vl;
  endtask

  task automatic look(int p, logic md, logic [63:0] a, logic [23:0] r);
    lk_en[p] = 1; lk_mode[p] = md; lk_addr[p] = a; lk_rgn[p] = r;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [51:0] va, vb;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_rgn[i] = '0;
    end
    exp_vec[0] = '0; exp_vec[1] = '0; exp_ppn[0] = '0; exp_ppn[1] = '0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      check("R1", "reset hit vector", 64'(lk_hit_vec[p]), 64'(0));
      check("R1", "reset page", 64'(lk_ppn[p]), 64'(0));
    end
    rst_n = 1;
    // R1: nothing valid after reset
    look(0, 0, 64'h0, 24'h0); look(1, 1, 64'h0, 24'h0);
    cycle("R1"); quiet();

    // R6 install, then R2/R3/R5 both ports, R4 page
    va = {47'h1234, 5'd3}; vb = {47'h55, 5'd3};
    do_write(3, va, 38'h2_abcd, 24'h77, 1); cycle("R6"); quiet();
    look(0, 0, {va, 12'h000}, 24'h77);
    look(1, 1, {14'h3fff, 38'h2_abcd, 12'hfff}, 24'h5);
    cycle("R2 R3 R4 R5");
    // R10 offset bits ignored
    look(0, 0, {va, 12'ha5c}, 24'h77); cycle("R10"); quiet();
    // R2 region mismatch misses
    look(0, 0, {va, 12'h0}, 24'h78); cycle("R2"); quiet();
    // R7 same-cycle write sees old contents
    do_write(3, vb, 38'h1_1111, 24'h77, 1);
    look(0, 0, {va, 12'h0}, 24'h77); cycle("R7"); quiet();
    look(0, 0, {va, 12'h0}, 24'h77); look(1, 0, {vb, 12'h0}, 24'h77); cycle("R6 R5"); quiet();
    // R9 hold while disabled
    lk_addr[0] = {vb, 12'h0}; lk_addr[1] = 64'h0; cycle("R9");
    // R6 removal with valid 0
    do_write(3, vb, 38'h1_1111, 24'h77, 0); cycle("R6"); quiet();
    look(1, 0, {vb, 12'h0}, 24'h77); cycle("R6"); quiet();
    // R3 multiple physical hits
    do_write(4, {47'h9, 5'd4}, 38'h42, 24'h1, 1); cycle("R6"); quiet();
    do_write(5, {47'h9, 5'd5}, 38'h42, 24'h2, 1); cycle("R6"); quiet();
    look(0, 1, {14'h0, 38'h42, 12'h0}, 24'h0); cycle("R3 R4"); quiet();
    // R8 flush together with a write
    do_write(6, {47'h2, 5'd6}, 38'h7, 24'h3, 1); inv_all = 1; cycle("R8"); quiet();
    look(0, 1, {14'h0, 38'h42, 12'h0}, 24'h0);
    look(1, 0, {47'h2, 5'd6, 12'h0}, 24'h3); cycle("R8"); quiet();

    // constrained random mix
    for (int c = 0; c < 4000; c++) begin
      quiet();
      if ($urandom_range(0, 2) == 0) begin
        int s = $urandom_range(0, N - 1);
        do_write(s, {47'($urandom_range(0, 3)), 5'(s)}, 38'($urandom_range(0, 3)),
                 24'($urandom_range(0, 1)), $urandom_range(0, 5) != 0);
      end
      if ($urandom_range(0, 60) == 0) inv_all = 1;
      for (int p = 0; p < 2; p++) begin
        int k = $urandom_range(0, N - 1);
        logic md = 1'($urandom_range(0, 1));
        logic [63:0] a;
        if ($urandom_range(0, 3) == 0) a = {$urandom(), $urandom()};
        else if (md) a = {14'($urandom()), m_ppn[k], 12'($urandom())};
        else a = {m_vpn[k], 12'($urandom())};
        if ($urandom_range(0, 4) != 0)
          look(p, md, a, ($urandom_range(0, 3) == 0) ? ~m_rgn[k] : m_rgn[k]);
        else begin
          lk_addr[p] = a; lk_mode[p] = md;
        end
      end
      cycle("R2 R3 R5 R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule